// File: doc/BRIEF.md
# Delay-Slot Program Counter Sequencer with Halt Control

This block owns the program counter of a small scalar core that fetches from a 4 KiB instruction memory. While the core runs it presents one word-aligned fetch address per cycle and moves forward by four bytes, wrapping inside the 12-bit address space. The execute stage reports a taken branch or jump together with its target. The sequencer lets the next sequential instruction, the delay slot, execute first and only then loads the target.

A run/halt flag gates all progress. A break reported by execute stops the core, sets a sticky "stopped by break" flag and, if break interrupts are enabled, raises a sticky interrupt request. Control logic outside the block can set or clear the halt flag. After a clear, fetch resumes at the held PC on the next cycle. A memory-mapped image of the PC is also presented, at a fixed base address plus the 12-bit PC.

Top module: `delay_slot_pc`

## Requirements
- R1: Reset clears the halt, broke and interrupt flags and the delay-slot phase. It loads the PC from `start_pc_i` with bits 1:0 forced to zero, so a start value of 0x103 gives a PC of 0x100.
- R2: In every cycle where halt is clear and no redirect is due, the PC advances by 4 modulo 4096, so 0xFFC is followed by 0x000.
- R3: `fetch_addr_o` equals the PC and always has bits 1:0 at zero. `fetch_en_o` is high exactly when halt is clear.
- R4: A taken branch in a running cycle makes the next PC the sequential one, with `delay_slot_o` high. The PC after that is the target with only bits 11:2 kept and bits 1:0 zero.
- R5: A taken branch reported during the delay-slot cycle is ignored, and the first target is loaded.
- R6: While halt is set, the PC, the phase and the broke and interrupt flags hold, and branch and break inputs have no effect.
- R7: A break in a running cycle sets halt and broke together in the next cycle. The break instruction itself completes, so the PC advances past it and then holds.
- R8: A break in a running cycle while `brk_irq_en_i` is high sets `irq_o` in the next cycle. Without the enable, `irq_o` stays low. Once set, `irq_o` stays set until reset.
- R9: `pc_image_o` equals 0x04001000 plus the zero-extended 12-bit PC.
- R10: `halt_set_i` sets halt for the next cycle, and the instruction of the current cycle still completes. `halt_clr_i` clears halt, and fetch resumes at the held PC. If both are high, set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_pc_i | input | 12 | PC loaded at reset |
| halt_set_i | input | 1 | External request to stop the core |
| halt_clr_i | input | 1 | External request to resume the core |
| brk_irq_en_i | input | 1 | Enables the interrupt request on break |
| br_taken_i | input | 1 | Execute reports a taken branch or jump |
| br_target_i | input | 32 | Branch or jump target address |
| brk_i | input | 1 | Execute reports a break instruction |
| fetch_addr_o | output | 12 | Word-aligned instruction memory address |
| fetch_en_o | output | 1 | High while the core runs |
| pc_image_o | output | 32 | Memory-mapped view of the PC |
| delay_slot_o | output | 1 | Current instruction sits in a delay slot |
| halt_o | output | 1 | Halt flag |
| broke_o | output | 1 | Stopped-by-break flag |
| irq_o | output | 1 | Break interrupt request |

## Verification
The bench builds the block with its defaults: a 12-bit PC and an image base of 0x04001000. Because the PC is only 12 bits wide, a start address of 0xFF8 reaches the wrap to zero within two cycles. With a 32-bit target, upper and low bits can be loaded that the mask must discard. Directed scenarios combine branches inside delay slots, breaks with and without the interrupt enable, and external halt control. These include simultaneous set and clear and stimulus applied while halted.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_SLOT = 1'b1
    } phase_e;
endpackage

// File: rtl/pcseq_wordmask.sv
module pcseq_wordmask #(
    parameter int IN_W = 32,
    parameter int PC_W = 12
) (
    input  logic [IN_W-1:0] addr_i,
    output logic [PC_W-1:0] addr_o
);
    localparam logic [PC_W-1:0] ALIGN_MASK = ~PC_W'(3);

    always_comb begin
        addr_o = PC_W'(addr_i) & ALIGN_MASK;
    end

    // R3
    always_comb begin
        word_aligned_chk: assert (addr_o[1:0] == 2'b00);
    end
endmodule

// File: rtl/pcseq_sched.sv
module pcseq_sched
    import pcseq_pkg::*;
#(
    parameter int PC_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] start_pc_i,
    input  logic            run_i,
    input  logic            br_taken_i,
    input  logic [PC_W-1:0] br_tgt_i,
    output logic [PC_W-1:0] pc_o,
    output logic            in_slot_o
);
    localparam logic [PC_W-1:0] STEP = PC_W'(4);

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic [PC_W-1:0] tgt;
        phase_e          ph;
    } sched_t;

    sched_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (run_i) begin
            if (cur_q.ph == PH_SLOT) begin
                nxt_d.pc = cur_q.tgt;
                nxt_d.ph = PH_IDLE;
            end else begin
                nxt_d.pc = cur_q.pc + STEP;
                if (br_taken_i) begin
                    nxt_d.tgt = br_tgt_i;
                    nxt_d.ph  = PH_SLOT;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.pc  <= start_pc_i;
            cur_q.tgt <= '0;
            cur_q.ph  <= PH_IDLE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign pc_o      = cur_q.pc;
    assign in_slot_o = (cur_q.ph == PH_SLOT);

    // R2
    seq_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !in_slot_o) |=> (pc_o == PC_W'($past(pc_o) + STEP)));
    // R4
    branch_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !in_slot_o && br_taken_i) |=> in_slot_o);
    // R5
    slot_leaves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && in_slot_o) |=> !in_slot_o);
    // R6
    halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> ($stable(pc_o) && $stable(in_slot_o)));
endmodule

// File: rtl/pcseq_status.sv
module pcseq_status (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_set_i,
    input  logic halt_clr_i,
    input  logic brk_i,
    input  logic brk_irq_en_i,
    output logic halt_o,
    output logic broke_o,
    output logic irq_o
);
    typedef struct packed {
        logic halt;
        logic broke;
        logic irq;
    } stat_t;

    stat_t cur_q, nxt_d;
    logic  brk_exec;

    always_comb begin
        brk_exec = brk_i && !cur_q.halt;
        nxt_d    = cur_q;
        if (halt_set_i || brk_exec) begin
            nxt_d.halt = 1'b1;
        end else if (halt_clr_i) begin
            nxt_d.halt = 1'b0;
        end
        if (brk_exec) begin
            nxt_d.broke = 1'b1;
            if (brk_irq_en_i) begin
                nxt_d.irq = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign halt_o  = cur_q.halt;
    assign broke_o = cur_q.broke;
    assign irq_o   = cur_q.irq;

    // R7
    brk_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_o && brk_i) |=> (halt_o && broke_o));
    // R8
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> irq_o);
    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_set_i |=> halt_o);
endmodule

// File: rtl/delay_slot_pc.sv
module delay_slot_pc #(
    parameter int          PC_W       = 12,
    parameter int          ADDR_W     = 32,
    parameter logic [31:0] IMAGE_BASE = 32'h0400_1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   start_pc_i,
    input  logic              halt_set_i,
    input  logic              halt_clr_i,
    input  logic              brk_irq_en_i,
    input  logic              br_taken_i,
    input  logic [ADDR_W-1:0] br_target_i,
    input  logic              brk_i,
    output logic [PC_W-1:0]   fetch_addr_o,
    output logic              fetch_en_o,
    output logic [31:0]       pc_image_o,
    output logic              delay_slot_o,
    output logic              halt_o,
    output logic              broke_o,
    output logic              irq_o
);
    logic [PC_W-1:0] start_al, tgt_al, pc;
    logic            halt;

    pcseq_wordmask #(.IN_W(PC_W), .PC_W(PC_W)) u_start_mask (
        .addr_i (start_pc_i),
        .addr_o (start_al)
    );

    pcseq_wordmask #(.IN_W(ADDR_W), .PC_W(PC_W)) u_tgt_mask (
        .addr_i (br_target_i),
        .addr_o (tgt_al)
    );

    pcseq_status u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .halt_set_i   (halt_set_i),
        .halt_clr_i   (halt_clr_i),
        .brk_i        (brk_i),
        .brk_irq_en_i (brk_irq_en_i),
        .halt_o       (halt),
        .broke_o      (broke_o),
        .irq_o        (irq_o)
    );

    pcseq_sched #(.PC_W(PC_W)) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_pc_i (start_al),
        .run_i      (!halt),
        .br_taken_i (br_taken_i),
        .br_tgt_i   (tgt_al),
        .pc_o       (pc),
        .in_slot_o  (delay_slot_o)
    );

    assign fetch_addr_o = pc;
    assign fetch_en_o   = !halt;
    assign halt_o       = halt;
    assign pc_image_o   = IMAGE_BASE + 32'(pc);

    // R9
    always_comb begin
        image_low_chk: assert (pc_image_o[PC_W-1:0] == fetch_addr_o);
    end
    // R3
    fetch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_o && !halt_clr_i) |=> !fetch_en_o);
endmodule

// File: tb/delay_slot_pc_tb.sv
module delay_slot_pc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] start_pc_i = 12'h103;
    logic        halt_set_i = 1'b0, halt_clr_i = 1'b0, brk_irq_en_i = 1'b0;
    logic        br_taken_i = 1'b0, brk_i = 1'b0;
    logic [31:0] br_target_i = '0;
    logic [11:0] fetch_addr_o;
    logic        fetch_en_o, delay_slot_o, halt_o, broke_o, irq_o;
    logic [31:0] pc_image_o;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    delay_slot_pc u_dut (
        .clk(clk), .rst_n(rst_n), .start_pc_i(start_pc_i),
        .halt_set_i(halt_set_i), .halt_clr_i(halt_clr_i),
        .brk_irq_en_i(brk_irq_en_i), .br_taken_i(br_taken_i),
        .br_target_i(br_target_i), .brk_i(brk_i),
        .fetch_addr_o(fetch_addr_o), .fetch_en_o(fetch_en_o),
        .pc_image_o(pc_image_o), .delay_slot_o(delay_slot_o),
        .halt_o(halt_o), .broke_o(broke_o), .irq_o(irq_o)
    );

    always #10 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(logic [11:0] sp);
        rst_n = 1'b0;
        start_pc_i = sp;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset(12'h103);
        chk("R1 pc", 32'(fetch_addr_o), 32'h100);
        chk("R1 flags", {29'b0, halt_o, broke_o, irq_o}, 32'h0);
        chk("R1 slot", 32'(delay_slot_o), 32'h0);
        chk("R3 fetch_en", 32'(fetch_en_o), 32'h1);
        chk("R9 image", pc_image_o, 32'h0400_1100);
    endtask

    task automatic t_advance();
        tick();
        chk("R2 step", 32'(fetch_addr_o), 32'h104);
        tick();
        chk("R2 step2", 32'(fetch_addr_o), 32'h108);
        chk("R9 image step", pc_image_o, 32'h0400_1108);
    endtask

    task automatic t_wrap();
        do_reset(12'hFF8);
        chk("R1 wrap start", 32'(fetch_addr_o), 32'hFF8);
        tick();
        chk("R2 pre-wrap", 32'(fetch_addr_o), 32'hFFC);
        chk("R9 image top", pc_image_o, 32'h0400_1FFC);
        tick();
        chk("R2 wrap", 32'(fetch_addr_o), 32'h000);
        chk("R9 image wrap", pc_image_o, 32'h0400_1000);
    endtask

    task automatic t_branch();
        logic [11:0] p;
        p = fetch_addr_o;
        br_taken_i = 1'b1;
        br_target_i = 32'h1234_5677;
        tick();
        br_taken_i = 1'b0;
        br_target_i = '0;
        chk("R4 slot pc", 32'(fetch_addr_o), 32'(12'(p + 12'd4)));
        chk("R4 slot flag", 32'(delay_slot_o), 32'h1);
        tick();
        chk("R4 target", 32'(fetch_addr_o), 32'h674);
        chk("R4 slot clear", 32'(delay_slot_o), 32'h0);
        chk("R3 aligned", 32'(fetch_addr_o[1:0]), 32'h0);
        tick();
        chk("R4 after target", 32'(fetch_addr_o), 32'h678);
    endtask

    task automatic t_slot_ignore();
        br_taken_i = 1'b1;
        br_target_i = 32'h0000_0200;
        tick();
        br_target_i = 32'h0000_0800;
        tick();
        br_taken_i = 1'b0;
        chk("R5 first target", 32'(fetch_addr_o), 32'h200);
        chk("R5 no second slot", 32'(delay_slot_o), 32'h0);
        tick();
        chk("R5 sequential", 32'(fetch_addr_o), 32'h204);
    endtask

    task automatic t_break_plain();
        logic [11:0] p;
        p = fetch_addr_o;
        brk_irq_en_i = 1'b0;
        brk_i = 1'b1;
        tick();
        brk_i = 1'b0;
        chk("R7 halt", 32'(halt_o), 32'h1);
        chk("R7 broke", 32'(broke_o), 32'h1);
        chk("R7 pc past break", 32'(fetch_addr_o), 32'(12'(p + 12'd4)));
        chk("R8 no irq", 32'(irq_o), 32'h0);
        chk("R3 fetch off", 32'(fetch_en_o), 32'h0);
        tick();
        tick();
        chk("R7 pc holds", 32'(fetch_addr_o), 32'(12'(p + 12'd4)));
        // R6: stimulus while halted has no effect
        br_taken_i = 1'b1;
        br_target_i = 32'h0000_0400;
        brk_i = 1'b1;
        brk_irq_en_i = 1'b1;
        tick();
        br_taken_i = 1'b0;
        brk_i = 1'b0;
        brk_irq_en_i = 1'b0;
        tick();
        chk("R6 pc frozen", 32'(fetch_addr_o), 32'(12'(p + 12'd4)));
        chk("R6 no slot", 32'(delay_slot_o), 32'h0);
        chk("R6 no irq", 32'(irq_o), 32'h0);
        halt_clr_i = 1'b1;
        tick();
        halt_clr_i = 1'b0;
        chk("R10 resume halt", 32'(halt_o), 32'h0);
        chk("R10 resume pc", 32'(fetch_addr_o), 32'(12'(p + 12'd4)));
        tick();
        chk("R10 runs again", 32'(fetch_addr_o), 32'(12'(p + 12'd8)));
        chk("R6 broke kept", 32'(broke_o), 32'h1);
    endtask

    task automatic t_break_irq();
        brk_irq_en_i = 1'b1;
        brk_i = 1'b1;
        tick();
        brk_i = 1'b0;
        brk_irq_en_i = 1'b0;
        chk("R8 irq set", 32'(irq_o), 32'h1);
        chk("R7 halt on irq break", 32'(halt_o), 32'h1);
        halt_clr_i = 1'b1;
        tick();
        halt_clr_i = 1'b0;
        tick();
        chk("R8 irq sticky", 32'(irq_o), 32'h1);
    endtask

    task automatic t_ext_halt();
        logic [11:0] p;
        do_reset(12'h040);
        p = fetch_addr_o;
        halt_set_i = 1'b1;
        tick();
        halt_set_i = 1'b0;
        chk("R10 set halts", 32'(halt_o), 32'h1);
        chk("R10 current completes", 32'(fetch_addr_o), 32'(12'(p + 12'd4)));
        chk("R10 broke untouched", 32'(broke_o), 32'h0);
        halt_set_i = 1'b1;
        halt_clr_i = 1'b1;
        tick();
        halt_set_i = 1'b0;
        halt_clr_i = 1'b0;
        chk("R10 set wins", 32'(halt_o), 32'h1);
        chk("R6 pc still", 32'(fetch_addr_o), 32'(12'(p + 12'd4)));
        halt_clr_i = 1'b1;
        tick();
        halt_clr_i = 1'b0;
        tick();
        chk("R10 restart advance", 32'(fetch_addr_o), 32'(12'(p + 12'd8)));
    endtask

    initial begin
        t_reset();
        t_advance();
        t_branch();
        t_slot_ignore();
        t_break_plain();
        t_break_irq();
        t_wrap();
        t_ext_halt();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule